// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block receives a serial configuration bitstream for one device in a chain of devices that share a single data path. An external configuration clock drives it. The block samples the serial input on every rising edge, looks for a start pattern, and reads a 24-bit length count. It then loads the first `FRAME_BITS` data bits into its own configuration shift register. Any data bits beyond its own frame are passed on to the next device, up to the length count.

The block copies the preamble (idle ones, start pattern and length field) and all overflow bits to a pass-through output, so the downstream device sees the same stream minus this device's frame. Each copied bit is launched on the falling edge that follows the rising edge that sampled it. The downstream device captures it half a period later, on the next rising edge. When the length count is reached, `cfg_done` rises and stays high. If the chain-ready input drops part way through, the block aborts, clears its state and raises `cfg_err`.

Top module: `cfg_chain_slave`

## Requirements
- R1: The block receives only while `mode_sel` is 3'b111 (the level that undriven, pulled-up mode pins present). With any other value, every state and register holds, `sdi` is ignored, and the value launched on `sdo` is 0.
- R2: In mode 111 with `chain_rdy` low before the start pattern, input bits are not examined and the value launched on `sdo` is 1. Capture begins only once `chain_rdy` is high.
- R3: While hunting, the block looks at the last eight bits received for the start pattern 1111_0010 (oldest bit first). Idle ones, the pattern bits and the length bits are each copied unchanged to `sdo`.
- R4: The 24 bits that follow the pattern form the length count, most significant bit first. It gives how many data bits the whole chain consumes after the length field.
- R5: The first `FRAME_BITS` data bits are shifted into `cfg_data` from bit 0 upward, each new bit entering bit 0. After a full frame, the first data bit sits in bit `FRAME_BITS-1`. While these bits arrive, the value launched on `sdo` is 1.
- R6: Data bits after the local frame, up to the length count, are copied unchanged to `sdo`.
- R7: A bit sampled on a rising edge appears on `sdo` at the following falling edge. `sdo` holds that value across the next rising edge.
- R8: `cfg_done` rises on the edge that samples the last counted data bit and stays high until reset. Later bits change neither `cfg_data` nor `cfg_done`, and the value launched on `sdo` for them is 1.
- R9: If the length count is smaller than `FRAME_BITS`, `cfg_done` rises after that many loaded bits. A length of zero raises `cfg_done` on the edge that samples the last length bit.
- R10: If `chain_rdy` is low on a rising edge during the length field, the frame load or the forward phase, the block clears `cfg_data` and sets `cfg_err`. `cfg_err` stays high until reset, `cfg_done` stays low, and the value launched on `sdo` is 1 from then on.
- R11: While `rst_n` is low, `cfg_done`, `cfg_err` and `sdo` are 0 and `cfg_data` is all zeros. Reset takes effect at once and is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | External configuration clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mode_sel | input | 3 | Mode pins; 3'b111 selects serial receive |
| chain_rdy | input | 1 | High when every device in the chain is ready |
| sdi | input | 1 | Serial data in, sampled on rising `cclk` |
| sdo | output | 1 | Pass-through data, launched on falling `cclk` |
| cfg_done | output | 1 | Length count reached, sticky |
| cfg_err | output | 1 | Capture aborted by chain-ready drop, sticky |
| cfg_data | output | FRAME_BITS | Local configuration shift register |

## Verification
Each bit goes through two registers on its way to `sdo`. A rising-edge stage holds the value to send, and a falling-edge stage drives the pin. The value for a bit sampled at edge N is therefore due from the falling edge after N and must still be present just after edge N+1. The bench's driver changes inputs 3.5 ns after a rising edge and queues the `sdo` value each bit should produce. The monitor pops one entry 3 ns after each rising edge, which is after the falling edge. At 1 ns after the next rising edge it checks that the pin has not yet moved on. `cfg_done`, `cfg_err` and `cfg_data` are registered on the edge that samples the deciding bit, so they are checked once the queue has drained, after the final data bit or the abort.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LEN,
    ST_LOAD,
    ST_FWD,
    ST_DONE,
    ST_ERR
  } cfg_state_e;

  localparam logic [2:0] MODE_SERIAL_RX = 3'b111;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_frame_sreg.sv
module cfg_frame_sreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] data
);

  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (clr) begin
      data_d = '0;
    end else if (shift_en) begin
      if (WIDTH > 1) begin
        data_d = {data_q[WIDTH-2:0], bit_in};
      end else begin
        data_d = {WIDTH{bit_in}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (clr || shift_en) begin
      data_q <= data_d;
    end
  end

  assign data = data_q;

endmodule

// File: rtl/cfg_launch.sv
module cfg_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_val,
  output logic sdo
);

  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
    end else begin
      rise_q <= fwd_val;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= rise_q;
    end
  end

  assign sdo = fall_q;

endmodule

// File: rtl/cfg_chain_ctrl.sv
module cfg_chain_ctrl
  import cfg_chain_pkg::*;
#(
  parameter int               FRAME_BITS  = 16,
  parameter int               LEN_BITS    = 24,
  parameter int               PRE_BITS    = 8,
  parameter logic [PRE_BITS-1:0] PRE_PATTERN = 8'hF2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       chain_rdy,
  input  logic       sdi,
  output logic       load_en,
  output logic       load_clr,
  output logic       fwd_val,
  output logic       done,
  output logic       err
);

  localparam int                  LIDX_W    = $clog2(LEN_BITS);
  localparam logic [LIDX_W-1:0]   LIDX_LAST = LIDX_W'(LEN_BITS - 1);
  localparam logic [LEN_BITS-1:0] FRAME_CNT = LEN_BITS'(FRAME_BITS);

  cfg_state_e          state_q, state_d;
  logic [PRE_BITS-1:0] pat_q, pat_d;
  logic [LEN_BITS-1:0] len_q, len_d;
  logic [LIDX_W-1:0]   lidx_q, lidx_d;
  logic [LEN_BITS-1:0] dcnt_q, dcnt_d;

  logic                active;
  logic                run;
  logic                abort;
  logic                upd_en;
  logic [PRE_BITS-1:0] pat_shift;
  logic [LEN_BITS-1:0] len_shift;
  logic [LEN_BITS-1:0] dcnt_inc;

  assign active    = (mode_sel == MODE_SERIAL_RX);
  assign run       = active && chain_rdy;
  assign abort     = active && !chain_rdy &&
                     (state_q == ST_LEN || state_q == ST_LOAD || state_q == ST_FWD);
  assign upd_en    = run || abort;
  assign pat_shift = {pat_q[PRE_BITS-2:0], sdi};
  assign len_shift = {len_q[LEN_BITS-2:0], sdi};
  assign dcnt_inc  = dcnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    pat_d   = pat_q;
    len_d   = len_q;
    lidx_d  = lidx_q;
    dcnt_d  = dcnt_q;
    if (abort) begin
      state_d = ST_ERR;
      pat_d   = '0;
      len_d   = '0;
      lidx_d  = '0;
      dcnt_d  = '0;
    end else if (run) begin
      unique case (state_q)
        ST_HUNT: begin
          pat_d = pat_shift;
          if (pat_shift == PRE_PATTERN) begin
            state_d = ST_LEN;
            len_d   = '0;
            lidx_d  = '0;
          end
        end
        ST_LEN: begin
          len_d  = len_shift;
          lidx_d = lidx_q + 1'b1;
          if (lidx_q == LIDX_LAST) begin
            dcnt_d  = '0;
            state_d = (len_shift == '0) ? ST_DONE : ST_LOAD;
          end
        end
        ST_LOAD: begin
          dcnt_d = dcnt_inc;
          if (dcnt_inc == len_q) begin
            state_d = ST_DONE;
          end else if (dcnt_inc == FRAME_CNT) begin
            state_d = ST_FWD;
          end
        end
        ST_FWD: begin
          dcnt_d = dcnt_inc;
          if (dcnt_inc == len_q) begin
            state_d = ST_DONE;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pat_q   <= '0;
      len_q   <= '0;
      lidx_q  <= '0;
      dcnt_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      pat_q   <= pat_d;
      len_q   <= len_d;
      lidx_q  <= lidx_d;
      dcnt_q  <= dcnt_d;
    end
  end

  always_comb begin
    if (!active) begin
      fwd_val = 1'b0;
    end else if (!chain_rdy) begin
      fwd_val = 1'b1;
    end else begin
      unique case (state_q)
        ST_HUNT, ST_LEN, ST_FWD: fwd_val = sdi;
        default:                 fwd_val = 1'b1;
      endcase
    end
  end

  assign load_en  = run && (state_q == ST_LOAD);
  assign load_clr = abort;
  assign done     = (state_q == ST_DONE);
  assign err      = (state_q == ST_ERR);

endmodule

// File: rtl/cfg_chain_slave.sv
module cfg_chain_slave #(
  parameter int FRAME_BITS = 16,
  parameter int LEN_BITS   = 24,
  parameter int RST_STAGES = 2
) (
  input  logic                  cclk,
  input  logic                  rst_n,
  input  logic [2:0]            mode_sel,
  input  logic                  chain_rdy,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  cfg_done,
  output logic                  cfg_err,
  output logic [FRAME_BITS-1:0] cfg_data
);

  logic rst_sync_n;
  logic load_en;
  logic load_clr;
  logic fwd_val;

  cfg_rst_sync #(
    .STAGES(RST_STAGES)
  ) rst_sync_i (
    .clk       (cclk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  cfg_chain_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .LEN_BITS   (LEN_BITS),
    .PRE_BITS   (8),
    .PRE_PATTERN(8'hF2)
  ) ctrl_i (
    .clk      (cclk),
    .rst_n    (rst_sync_n),
    .mode_sel (mode_sel),
    .chain_rdy(chain_rdy),
    .sdi      (sdi),
    .load_en  (load_en),
    .load_clr (load_clr),
    .fwd_val  (fwd_val),
    .done     (cfg_done),
    .err      (cfg_err)
  );

  cfg_frame_sreg #(
    .WIDTH(FRAME_BITS)
  ) sreg_i (
    .clk     (cclk),
    .rst_n   (rst_sync_n),
    .clr     (load_clr),
    .shift_en(load_en),
    .bit_in  (sdi),
    .data    (cfg_data)
  );

  cfg_launch launch_i (
    .clk    (cclk),
    .rst_n  (rst_sync_n),
    .fwd_val(fwd_val),
    .sdo    (sdo)
  );

endmodule

// File: rtl/cfg_chain_chk.sv
module cfg_chain_chk #(
  parameter int FRAME_BITS = 16
) (
  input logic                  cclk,
  input logic                  rst_n,
  input logic [2:0]            mode_sel,
  input logic                  chain_rdy,
  input logic                  sdo,
  input logic                  cfg_done,
  input logic                  cfg_err,
  input logic [FRAME_BITS-1:0] cfg_data
);

  a_r1_idle_mode_sdo_low: assert property (@(posedge cclk) disable iff (!rst_n)
    (mode_sel != 3'b111) |=> (sdo == 1'b0));

  a_r8_done_sticky: assert property (@(posedge cclk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  a_r8_data_frozen: assert property (@(posedge cclk) disable iff (!rst_n)
    cfg_done |=> $stable(cfg_data));

  a_r10_err_sticky: assert property (@(posedge cclk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r10_err_cause: assert property (@(posedge cclk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(!chain_rdy && mode_sel == 3'b111));

  a_r10_err_excl_done: assert property (@(posedge cclk) disable iff (!rst_n)
    !(cfg_err && cfg_done));

  a_r8_done_cause: assert property (@(posedge cclk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(chain_rdy && mode_sel == 3'b111));

endmodule

bind cfg_chain_slave cfg_chain_chk #(
  .FRAME_BITS(FRAME_BITS)
) chk_i (
  .cclk     (cclk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .chain_rdy(chain_rdy),
  .sdo      (sdo),
  .cfg_done (cfg_done),
  .cfg_err  (cfg_err),
  .cfg_data (cfg_data)
);

// File: tb/cfg_chain_slave_tb.sv
`timescale 1ns/100ps
module cfg_chain_slave_tb_top;

  localparam int FB = 16;

  logic          clk;
  logic          rst_n;
  logic [2:0]    mode_sel;
  logic          chain_rdy;
  logic          sdi;
  logic          sdo;
  logic          cfg_done;
  logic          cfg_err;
  logic [FB-1:0] cfg_data;

  int   n_checks;
  int   n_fail;
  bit   finished;
  logic exp_q[$];
  logic [FB-1:0] exp_cfg;

  cfg_chain_slave #(.FRAME_BITS(FB)) dut_i (
    .cclk     (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .chain_rdy(chain_rdy),
    .sdi      (sdi),
    .sdo      (sdo),
    .cfg_done (cfg_done),
    .cfg_err  (cfg_err),
    .cfg_data (cfg_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: R7 launch on falling edge, held over next rising edge
  logic last_exp;
  bit   last_valid;
  initial begin
    last_valid = 0;
    last_exp   = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (last_valid) chk("R7 sdo held past rising edge", sdo, last_exp);
      #2;
      if (exp_q.size() != 0) begin
        last_exp   = exp_q.pop_front();
        last_valid = 1;
        chk("R1/R2/R3/R5/R6/R8 sdo stream", sdo, last_exp);
      end else begin
        last_valid = 0;
      end
    end
  end

  task automatic drive_bit(input logic [2:0] m, input logic r, input logic b, input logic e);
    @(posedge clk);
    #3.5;
    mode_sel  = m;
    chain_rdy = r;
    sdi       = b;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
    #3.2;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #3.5;
    rst_n     = 1'b0;
    mode_sel  = 3'b111;
    chain_rdy = 1'b1;
    sdi       = 1'b1;
    exp_cfg   = '0;
    repeat (2) @(posedge clk);
    #3;
    chk("R11 reset sdo", sdo, 0);
    chk("R11 reset done", cfg_done, 0);
    chk("R11 reset err", cfg_err, 0);
    chk("R11 reset data", cfg_data, 0);
    #0.5;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  // idle ones, pattern 1111_0010, 24-bit length MSB first, data, trailing bits
  task automatic run_frame(input logic [2:0] m, input int idle, input int len,
                           input int data_bits, input int extra, input logic [63:0] pay);
    logic on;
    logic [7:0] pat;
    logic [23:0] lv;
    on  = (m == 3'b111);
    pat = 8'hF2;
    lv  = 24'(len);
    for (int i = 0; i < idle; i++) drive_bit(m, 1'b1, 1'b1, on ? 1'b1 : 1'b0);
    for (int i = 7; i >= 0; i--) drive_bit(m, 1'b1, pat[i], on ? pat[i] : 1'b0);
    for (int i = 23; i >= 0; i--) drive_bit(m, 1'b1, lv[i], on ? lv[i] : 1'b0);
    for (int i = 0; i < data_bits; i++) begin
      logic b;
      b = pay[i % 64];
      if (!on) drive_bit(m, 1'b1, b, 1'b0);
      else if (i >= len) drive_bit(m, 1'b1, b, 1'b1);
      else if (i < FB) begin
        drive_bit(m, 1'b1, b, 1'b1);
        exp_cfg = {exp_cfg[FB-2:0], b};
      end else drive_bit(m, 1'b1, b, b);
    end
    for (int i = 0; i < extra; i++) drive_bit(m, 1'b1, i[0], on ? 1'b1 : 1'b0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 0;
    rst_n    = 1'b0;
    mode_sel = 3'b111;
    chain_rdy = 1'b1;
    sdi      = 1'b1;
    exp_cfg  = '0;

    // R11 reset, then R3 R4 R5 R6 R8: full frame plus 12 overflow bits
    do_reset();
    run_frame(3'b111, 3, 28, 28, 6, 64'hC3A5_5A3C_96E1_B74D);
    drain();
    chk("R8 done after length count", cfg_done, 1);
    chk("R5 local frame contents", cfg_data, exp_cfg);
    chk("R10 no error on clean frame", cfg_err, 0);

    // R1: non-111 mode ignores stream, then 111 stream is recognised from hunt
    do_reset();
    run_frame(3'b011, 2, 20, 20, 0, 64'h0000_0000_F0F0_1234);
    drain();
    chk("R1 no done in other mode", cfg_done, 0);
    chk("R1 no load in other mode", cfg_data, 0);
    run_frame(3'b111, 2, 20, 20, 0, 64'h0000_0000_F0F0_1234);
    drain();
    chk("R1 done once mode is 111", cfg_done, 1);
    chk("R1 data once mode is 111", cfg_data, exp_cfg);

    // R2: pattern sent while chain not ready is ignored
    do_reset();
    for (int i = 7; i >= 0; i--) drive_bit(3'b111, 1'b0, 8'hF2 >> i, 1'b1);
    run_frame(3'b111, 1, 16, 16, 3, 64'h0000_0000_0000_ABCD);
    drain();
    chk("R2 frame after ready completes", cfg_done, 1);
    chk("R2 frame data", cfg_data, exp_cfg);

    // R9: length shorter than frame
    do_reset();
    run_frame(3'b111, 2, 5, 5, 4, 64'h0000_0000_0000_0016);
    drain();
    chk("R9 short length done", cfg_done, 1);
    chk("R9 short length data", cfg_data, 16'h000D);

    // R9: length zero
    do_reset();
    run_frame(3'b111, 2, 0, 0, 4, 64'h0);
    drain();
    chk("R9 zero length done", cfg_done, 1);
    chk("R9 zero length data", cfg_data, 0);

    // R10: chain-ready drops during frame load
    do_reset();
    run_frame(3'b111, 2, 40, 6, 0, 64'h0000_0000_0000_003F);
    drive_bit(3'b111, 1'b0, 1'b0, 1'b1);
    drive_bit(3'b111, 1'b1, 1'b0, 1'b1);
    drive_bit(3'b111, 1'b1, 1'b1, 1'b1);
    drain();
    chk("R10 error set", cfg_err, 1);
    chk("R10 data cleared", cfg_data, 0);
    chk("R10 no done", cfg_done, 0);
    repeat (4) drive_bit(3'b111, 1'b1, 1'b0, 1'b1);
    drain();
    chk("R10 error sticky", cfg_err, 1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule